// File: doc/BRIEF.md
# SDRAM Refresh Command Scheduler

This block sits on the controller side of a synchronous DRAM and keeps the memory refreshed. A free-running interval counter adds one owed refresh every `REFI_CYCLES` clocks. Up to `MAX_OWED` owed refreshes are held. While any are owed, the block raises a request to the main access arbiter. When the arbiter grants, the block precharges all banks, waits `TRP_CYCLES`, and then issues every owed auto-refresh back to back, spaced `TRC_CYCLES` apart. A busy flag stops the arbiter from issuing accesses from the precharge until one row-cycle time after the last refresh.

The block also places the device in self refresh on request. A level request `srReq` asks for the same grant. The block then precharges all banks, issues the self-refresh entry command, and holds clock enable low for as long as `srReq` stays high. When `srReq` drops, clock enable returns high with NOP on the command pins. Busy stays set for one more row-cycle time. Any refreshes still owed are dropped on entry, and the interval counter sits at zero while the device refreshes itself.

All command pins are registered. A command decided in one cycle appears on the pins on the next cycle. The parameters need `TRP_CYCLES` and `TRC_CYCLES` of at least 2.

Top module: `sdram_refresh_sched`

## Requirements
- R1: During and just after reset the pins show NOP (`rasN`,`casN`,`weN` all 1, `a10` 0), with `cke` 1, `busy` 0 and `refReq` 0.
- R2: With no grant, `refReq` first rises about `REFI_CYCLES` clocks after reset is released, within ±2 cycles.
- R3: A granted refresh starts with precharge-all (`rasN`=0, `casN`=1, `weN`=0, `a10`=1, `cke`=1). The first auto-refresh (`rasN`=0, `casN`=0, `weN`=1, `cke`=1) follows exactly `TRP_CYCLES` cycles later.
- R4: Owed refreshes are issued back to back, exactly `TRC_CYCLES` cycles apart, until none are owed.
- R5: At most `MAX_OWED` refreshes are held. After a long postponement, a grant yields exactly `MAX_OWED` auto-refresh commands.
- R6: `busy` rises in the same cycle as precharge-all. It stays high until it falls exactly `TRC_CYCLES` cycles after the last auto-refresh.
- R7: A self-refresh grant gives precharge-all, then, `TRP_CYCLES` later, the entry command (`cke`=0, `rasN`=0, `casN`=0, `weN`=1). `cke` then stays low with NOP pins while `srReq` is high.
- R8: When `srReq` falls, `cke` returns to 1 with NOP. `busy` falls exactly `TRC_CYCLES` later. Owed refreshes are cleared, so `refReq` stays low for at least `REFI_CYCLES`-10 cycles after exit.
- R9: In every cycle without a command the pins show NOP. No command is issued and `busy` stays low while `grant` is high and `refReq` is low.
- R10: `refReq` is high only while the scheduler is idle and a refresh is owed or `srReq` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| srReq | input | 1 | Level request to hold the device in self refresh |
| grant | input | 1 | Arbiter grant; acted on only while `refReq` is high |
| refReq | output | 1 | Request to the arbiter for the command bus |
| busy | output | 1 | Accesses blocked |
| cke | output | 1 | Clock-enable pin |
| rasN | output | 1 | Row strobe pin, active low |
| casN | output | 1 | Column strobe pin, active low |
| weN | output | 1 | Write-enable pin, active low |
| a10 | output | 1 | Address bit 10, high for precharge-all |

## Verification
The bench uses `REFI_CYCLES`=100, `TRC_CYCLES`=6, `TRP_CYCLES`=3 and `MAX_OWED`=8. With these values, ten refresh intervals of postponement fill the owed counter well past saturation. A full drain of eight refreshes still ends before the next interval tick, so the exact count of commands can be checked. The short tRP and tRC make every gap and busy window distinct and quick to measure, and a self-refresh hold of several intervals shows that owed work is dropped.

// File: rtl/sdrf_pkg.sv
package sdrf_pkg;
  typedef enum logic [1:0] {CMD_NOP, CMD_PREA, CMD_REF, CMD_SRE} cmd_e;

  typedef struct packed {
    cmd_e cmd;       // command to place on the pins next cycle
    logic ckeLow;    // hold clock enable low
    logic busy;      // block the arbiter
    logic refDone;   // one owed refresh consumed
    logic owedClr;   // drop all owed refreshes
    logic waitLoad;  // start a wait window
    logic waitRc;    // 1: window is tRC, 0: window is tRP
  } strobe_t;
endpackage

// File: rtl/sdrf_ctrl.sv
module sdrf_ctrl
  import sdrf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    srReq,
  input  logic    grant,
  input  logic    owedNz,
  input  logic    waitDone,
  output logic    refReq,
  output strobe_t stb
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_WRP, ST_REF, ST_WRC, ST_SRE, ST_SELF, ST_SRX
  } state_e;

  state_e state, nextState;
  logic   srPath, nextSrPath;

  assign refReq = (state == ST_IDLE) && (owedNz || srReq);

  always_comb begin
    nextState  = state;
    nextSrPath = srPath;
    stb        = '0;
    stb.cmd    = CMD_NOP;
    unique case (state)
      ST_IDLE: if (refReq && grant) begin
        nextState  = ST_PRE;
        nextSrPath = srReq;
      end
      ST_PRE: begin
        stb.cmd      = CMD_PREA;
        stb.busy     = 1'b1;
        stb.waitLoad = 1'b1;
        nextState    = ST_WRP;
      end
      ST_WRP: begin
        stb.busy = 1'b1;
        if (waitDone) nextState = srPath ? ST_SRE : ST_REF;
      end
      ST_REF: begin
        stb.cmd      = CMD_REF;
        stb.busy     = 1'b1;
        stb.refDone  = 1'b1;
        stb.waitLoad = 1'b1;
        stb.waitRc   = 1'b1;
        nextState    = ST_WRC;
      end
      ST_WRC: begin
        stb.busy = 1'b1;
        if (waitDone) begin
          nextState  = owedNz ? ST_REF : ST_IDLE;
          nextSrPath = 1'b0;
        end
      end
      ST_SRE: begin
        stb.cmd     = CMD_SRE;
        stb.ckeLow  = 1'b1;
        stb.busy    = 1'b1;
        stb.owedClr = 1'b1;
        nextState   = ST_SELF;
      end
      ST_SELF: begin
        stb.ckeLow  = 1'b1;
        stb.busy    = 1'b1;
        stb.owedClr = 1'b1;
        if (!srReq) nextState = ST_SRX;
      end
      ST_SRX: begin
        stb.busy     = 1'b1;
        stb.waitLoad = 1'b1;
        stb.waitRc   = 1'b1;
        nextState    = ST_WRC;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      srPath <= 1'b0;
    end else begin
      state  <= nextState;
      srPath <= nextSrPath;
    end
  end

  // R9
  grant_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !refReq) |=> (state == ST_IDLE));

  // R10
  req_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !refReq);
endmodule

// File: rtl/sdrf_datapath.sv
module sdrf_datapath
  import sdrf_pkg::*;
#(
  parameter int REFI_CYCLES = 1560,
  parameter int TRC_CYCLES  = 9,
  parameter int TRP_CYCLES  = 3,
  parameter int MAX_OWED    = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output logic    owedNz,
  output logic    waitDone,
  output logic    busy,
  output logic    cke,
  output logic    rasN,
  output logic    casN,
  output logic    weN,
  output logic    a10
);
  localparam int IntW  = $clog2(REFI_CYCLES + 1);
  localparam int OwedW = $clog2(MAX_OWED + 1);
  localparam int WaitMax = (TRC_CYCLES > TRP_CYCLES) ? TRC_CYCLES : TRP_CYCLES;
  localparam int WaitW = $clog2(WaitMax + 1);
  localparam logic [IntW-1:0]  IntLast = IntW'(REFI_CYCLES - 1);
  localparam logic [OwedW-1:0] OwedTop = OwedW'(MAX_OWED);

  logic [IntW-1:0]  intCnt;
  logic [OwedW-1:0] owedCnt;
  logic [WaitW-1:0] waitCnt;
  logic             tick;

  assign tick     = !stb.ckeLow && (intCnt == IntLast);
  assign owedNz   = (owedCnt != '0);
  assign waitDone = (waitCnt == WaitW'(1));

  always_ff @(posedge clk) begin
    if (!rstN || stb.ckeLow || tick) intCnt <= '0;
    else                             intCnt <= intCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.owedClr)                           owedCnt <= '0;
    else if (tick && !stb.refDone && owedCnt != OwedTop) owedCnt <= owedCnt + 1'b1;
    else if (stb.refDone && !tick && owedNz)            owedCnt <= owedCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              waitCnt <= '0;
    else if (stb.waitLoad)  waitCnt <= stb.waitRc ? WaitW'(TRC_CYCLES - 1) : WaitW'(TRP_CYCLES - 1);
    else if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {rasN, casN, weN} <= 3'b111;
      a10  <= 1'b0;
      cke  <= 1'b1;
      busy <= 1'b0;
    end else begin
      cke  <= !stb.ckeLow;
      busy <= stb.busy;
      a10  <= (stb.cmd == CMD_PREA);
      unique case (stb.cmd)
        CMD_PREA: {rasN, casN, weN} <= 3'b010;
        CMD_REF,
        CMD_SRE:  {rasN, casN, weN} <= 3'b001;
        default:  {rasN, casN, weN} <= 3'b111;
      endcase
    end
  end

  // R5
  owed_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    owedCnt <= OwedTop);

  // R6
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rasN && casN && weN) |-> busy);

  // R3
  ref_after_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cke && !rasN && !casN && weN) |-> $past(busy));

  // R7
  self_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && $past(!cke)) |-> (rasN && casN && weN));

  // R8
  exit_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (rasN && casN && weN && busy));
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdrf_pkg::*;
#(
  parameter int REFI_CYCLES = 1560,
  parameter int TRC_CYCLES  = 9,
  parameter int TRP_CYCLES  = 3,
  parameter int MAX_OWED    = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic srReq,
  input  logic grant,
  output logic refReq,
  output logic busy,
  output logic cke,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic a10
);
  strobe_t stb;
  logic    owedNz;
  logic    waitDone;

  sdrf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .srReq(srReq), .grant(grant),
    .owedNz(owedNz), .waitDone(waitDone), .refReq(refReq), .stb(stb)
  );

  sdrf_datapath #(
    .REFI_CYCLES(REFI_CYCLES), .TRC_CYCLES(TRC_CYCLES),
    .TRP_CYCLES(TRP_CYCLES), .MAX_OWED(MAX_OWED)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .owedNz(owedNz), .waitDone(waitDone),
    .busy(busy), .cke(cke), .rasN(rasN), .casN(casN), .weN(weN), .a10(a10)
  );
endmodule

// File: tb/sdram_refresh_sched_bench.sv
module sdram_refresh_sched_bench;
  localparam int REFI = 100;
  localparam int TRC  = 6;
  localparam int TRP  = 3;
  localparam int MAXO = 8;

  typedef enum int {EV_PREA, EV_REF, EV_SRE, EV_SRX} ev_e;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srReq = 1'b0;
  logic autoGrant = 1'b0;
  logic forceGrant = 1'b0;
  logic grant, refReq, busy, cke, rasN, casN, weN, a10;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  ev_e expQ[$];

  assign grant = (autoGrant && refReq) || forceGrant;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_refresh_sched #(
    .REFI_CYCLES(REFI), .TRC_CYCLES(TRC), .TRP_CYCLES(TRP), .MAX_OWED(MAXO)
  ) u_sdram_refresh_sched (
    .clk(clk), .rstN(rstN), .srReq(srReq), .grant(grant), .refReq(refReq),
    .busy(busy), .cke(cke), .rasN(rasN), .casN(casN), .weN(weN), .a10(a10)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectEv(input ev_e e);
    expQ.push_back(e);
  endtask

  // Monitor: decode pins away from the edge, compare against the queue, time gaps
  int  lastPre = -1000, lastRef = -1000, lastAnchor = -1000;
  logic prevCke = 1'b1, prevBusy = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      bit   isEv;
      ev_e  ev;
      isEv = 1'b0;
      ev   = EV_PREA;
      if (!prevCke && cke) begin
        isEv = 1'b1; ev = EV_SRX;
      end else if (cke && !rasN && casN && !weN && a10) begin
        isEv = 1'b1; ev = EV_PREA;
      end else if (cke && !rasN && !casN && weN) begin
        isEv = 1'b1; ev = EV_REF;
      end else if (!cke && prevCke && !rasN && !casN && weN) begin
        isEv = 1'b1; ev = EV_SRE;
      end else if (!(rasN && casN && weN && !a10)) begin
        check("R9 stray pin state", {28'd0, rasN, casN, weN, a10}, 4'b1110);
      end
      if (isEv) begin
        if (expQ.size() == 0) begin
          check("R9 unexpected command", int'(ev), -1);
        end else begin
          check("R3/R4/R7/R8 command order", int'(ev), int'(expQ.pop_front()));
        end
        check("R6 busy during command", int'(busy), 1);
        if (ev == EV_PREA) begin
          lastPre = cyc;
          check("R6 busy rises with precharge", int'(prevBusy), 0);
        end
        if (ev == EV_REF) begin
          if (lastRef > lastPre) check("R4 refresh spacing", cyc - lastRef, TRC);
          else                   check("R3 precharge to refresh", cyc - lastPre, TRP);
          lastRef = cyc; lastAnchor = cyc;
        end
        if (ev == EV_SRE) check("R7 precharge to entry", cyc - lastPre, TRP);
        if (ev == EV_SRX) lastAnchor = cyc;
      end
      if (prevBusy && !busy) check("R6/R8 busy release", cyc - lastAnchor, TRC);
      prevCke  = cke;
      prevBusy = busy;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic waitBusyDone();
    @(posedge busy);
    @(negedge busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int relCyc;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 rasN", int'(rasN), 1);
    check("R1 casN", int'(casN), 1);
    check("R1 weN", int'(weN), 1);
    check("R1 a10", int'(a10), 0);
    check("R1 cke", int'(cke), 1);
    check("R1 busy", int'(busy), 0);
    check("R1 refReq", int'(refReq), 0);
    rstN = 1'b1;
    relCyc = cyc;
    @(negedge clk);
    check("R1 busy after release", int'(busy), 0);

    // R2: first request timing
    @(posedge refReq);
    @(negedge clk);
    total++;
    if ((cyc - relCyc) < REFI - 2 || (cyc - relCyc) > REFI + 2) begin
      bad++;
      $display("FAIL R2 request delay actual=%0d expected=%0d", cyc - relCyc, REFI);
    end

    // R3/R6: single granted refresh
    expectEv(EV_PREA);
    expectEv(EV_REF);
    autoGrant = 1'b1;
    waitBusyDone();
    autoGrant = 1'b0;
    check("R3 queue drained", expQ.size(), 0);
    check("R10 request low after drain", int'(refReq), 0);

    // R4/R5: postpone well past saturation, then drain
    @(posedge refReq);
    repeat (9 * REFI + 10) @(negedge clk);
    check("R10 request held while postponed", int'(refReq), 1);
    expectEv(EV_PREA);
    for (int i = 0; i < MAXO; i++) expectEv(EV_REF);
    autoGrant = 1'b1;
    waitBusyDone();
    autoGrant = 1'b0;
    check("R5 saturated drain count", expQ.size(), 0);
    check("R4 nothing owed after drain", int'(refReq), 0);

    // R9: grant with no request is ignored
    forceGrant = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) check("R9 busy under stray grant", int'(busy), 0);
    end
    forceGrant = 1'b0;
    check("R9 idle after stray grant", int'(busy), 0);

    // R7/R8: self refresh
    srReq = 1'b1;
    expectEv(EV_PREA);
    expectEv(EV_SRE);
    autoGrant = 1'b1;
    @(negedge cke);
    for (int i = 0; i < 3 * REFI; i++) begin
      @(negedge clk);
      if (cke || refReq) check("R7 cke low in self refresh", int'(cke), 0);
    end
    check("R7 busy in self refresh", int'(busy), 1);
    expectEv(EV_SRX);
    srReq = 1'b0;
    @(negedge busy);
    autoGrant = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 exit sequence seen", expQ.size(), 0);
    for (int i = 0; i < REFI - 10; i++) begin
      @(negedge clk);
      if (refReq) check("R8 owed cleared", int'(refReq), 0);
    end
    check("R8 no request after exit", int'(refReq), 0);
    check("R8 cke high after exit", int'(cke), 1);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule